// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shift engine of an SPI master. It takes one word at a time from a transmit FIFO, shifts it out on the data output, and samples the data input on the opposite clock edge. Each completed word is pushed into a receive FIFO. The word length (1 to 32 bits), clock polarity, sampling phase, bit order, idle data level and a 16-bit baud reload value all come from static configuration inputs. Software changes these inputs only while the engine is not busy.

The transmitter and the receiver can each be switched off. With the transmitter on, a word starts whenever the transmit FIFO holds data. With the transmitter off and the receiver on, the engine runs in receive-only mode. In that mode a byte-count request starts the clock, and the engine runs words until the to-do count reaches zero, driving the idle level on the data output. With both switched off the engine stays idle.

Two one-cycle status pulses report faults. One reports a word that completed while the transmit FIFO was empty. The other reports a received word that was dropped because the receive FIFO was full. Chip selects, FIFO storage and register access sit outside this block.

Top module: `spim_serial_core`

## Requirements
- R1: A word has `cfg_len_m1 + 1` bits (1 to 32). The received word appears on `rx_data` in bits `cfg_len_m1..0`, and the bits above it are zero.
- R2: `sck` rests at `cfg_cpol` while idle and makes exactly 2·N transitions per word of N bits, ending back at `cfg_cpol`.
- R3: With `cfg_lead_sample` = 1 (CPHA 0), the first bit is on `mosi` before the first transition, input is sampled on leading transitions and output changes on trailing ones. With `cfg_lead_sample` = 0 (CPHA 1), output changes on leading transitions after the first and input is sampled on trailing ones.
- R4: With `cfg_msb_first` = 1, bit N-1 goes out first and the first received bit lands in bit N-1. With 0, bit 0 goes first and the first received bit lands in bit 0.
- R5: Each `sck` half-period lasts `cfg_reload + 1` clock cycles, so `busy` stays high for 2·N·(`cfg_reload` + 1) cycles per word.
- R6: `mosi` equals `cfg_idle_lvl` whenever `busy` is low, and for the whole word when the transmitter is off.
- R7: With `cfg_tx_off` = 0, a word starts only when `tx_valid` is high and the engine is idle, and `tx_pop` is high in that cycle. With both `cfg_tx_off` and `cfg_rx_off` high, no word starts.
- R8: In receive-only mode (`cfg_tx_off` = 1, `cfg_rx_off` = 0), `rxreq_wr` loads `rxreq_cnt` into `rx_todo` only when `rx_todo` is zero and is ignored otherwise. Each word start subtracts ceil(N/8) from `rx_todo`, flooring at zero, and words run while `rx_todo` is nonzero.
- R9: `busy` is low after reset and is high from the word start to the final `sck` transition.
- R10: If `rx_full` is high when a word completes with the receiver on, `rx_overflow` pulses for one cycle and the word is not pushed. Otherwise `rx_push` pulses for one cycle.
- R11: `tx_underflow` pulses for one cycle when a word completes in transmit mode while `tx_valid` is low. Back-to-back words from a non-empty FIFO produce no pulse.
- R12: With `cfg_rx_off` = 1, no word is pushed to the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_m1 | input | 5 | Bits per word minus one |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_lead_sample | input | 1 | 1: sample on leading transition (CPHA 0); 0: CPHA 1 |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_idle_lvl | input | 1 | `mosi` level when not transmitting |
| cfg_tx_off | input | 1 | Transmitter switched off |
| cfg_rx_off | input | 1 | Receiver switched off |
| cfg_reload | input | 16 | Baud reload; half-period is reload+1 cycles |
| tx_valid | input | 1 | Transmit FIFO non-empty |
| tx_data | input | 32 | Head word of transmit FIFO |
| tx_pop | output | 1 | Take the head word of the transmit FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push `rx_data` into receive FIFO |
| rx_data | output | 32 | Received word, right-aligned |
| rxreq_wr | input | 1 | Write a receive-only byte request |
| rxreq_cnt | input | 16 | Requested byte count |
| rx_todo | output | 16 | Bytes still to be received |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is being shifted |
| tx_underflow | output | 1 | Word completed with transmit FIFO empty |
| rx_overflow | output | 1 | Received word dropped, FIFO full |

## Verification
The bench builds the engine with its default parameters: 16-bit reload, 32-bit maximum word and a 16-bit request counter. This puts both extremes of word length, 1 and 32 bits, within reach together with all four clock modes and both bit orders. Small reload values keep every word short while still showing that the half-period length follows the reload. A behavioural slave decodes the wire independently of the design. Receive-only runs use a request that is not a multiple of the per-word byte count, so the floor at zero and the ignored mid-run request are exercised.

// File: rtl/spim_serial_core.sv
module spim_serial_core #(
  parameter int DIV_W    = 16,
  parameter int WORD_MAX = 32,
  parameter int REQ_W    = 16,
  localparam int LEN_W   = $clog2(WORD_MAX),
  localparam int EDGE_W  = LEN_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    cfg_len_m1,
  input  logic                cfg_cpol,
  input  logic                cfg_lead_sample,
  input  logic                cfg_msb_first,
  input  logic                cfg_idle_lvl,
  input  logic                cfg_tx_off,
  input  logic                cfg_rx_off,
  input  logic [DIV_W-1:0]    cfg_reload,
  input  logic                tx_valid,
  input  logic [WORD_MAX-1:0] tx_data,
  output logic                tx_pop,
  input  logic                rx_full,
  output logic                rx_push,
  output logic [WORD_MAX-1:0] rx_data,
  input  logic                rxreq_wr,
  input  logic [REQ_W-1:0]    rxreq_cnt,
  output logic [REQ_W-1:0]    rx_todo,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                busy,
  output logic                tx_underflow,
  output logic                rx_overflow
);

  logic [DIV_W-1:0]    div_q;
  logic [EDGE_W-1:0]   edge_q;
  logic [LEN_W-1:0]    bit_q;
  logic [WORD_MAX-1:0] txw_q, rxw_q, rx_next;
  logic [REQ_W-1:0]    todo_q;
  logic                busy_q, tgl_q;

  wire tx_mode  = !cfg_tx_off;
  wire rxo_mode = cfg_tx_off && !cfg_rx_off;
  wire start    = !busy_q && ((tx_mode && tx_valid) || (rxo_mode && todo_q != '0));
  wire tick     = busy_q && div_q == '0;
  wire lead     = !edge_q[0];
  wire last     = edge_q == {cfg_len_m1, 1'b1};
  wire smp      = tick && (lead == cfg_lead_sample);
  wire adv      = tick && (cfg_lead_sample ? (!lead && !last) : (lead && edge_q != '0));

  wire [LEN_W-1:0] pos = cfg_msb_first ? cfg_len_m1 - bit_q : bit_q;
  wire [REQ_W-1:0] bpw = REQ_W'(cfg_len_m1 >> 3) + REQ_W'(1);

  assign tx_pop  = start && tx_mode;
  assign busy    = busy_q;
  assign rx_todo = todo_q;
  assign sck     = cfg_cpol ^ tgl_q;
  assign mosi    = (busy_q && tx_mode) ? txw_q[pos] : cfg_idle_lvl;

  always_comb begin
    rx_next = rxw_q;
    if (smp) rx_next[pos] = miso;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      tgl_q        <= 1'b0;
      div_q        <= '0;
      edge_q       <= '0;
      bit_q        <= '0;
      txw_q        <= '0;
      rxw_q        <= '0;
      todo_q       <= '0;
      rx_data      <= '0;
      rx_push      <= 1'b0;
      rx_overflow  <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      rx_push      <= 1'b0;
      rx_overflow  <= 1'b0;
      tx_underflow <= 1'b0;
      if (rxreq_wr && todo_q == '0) todo_q <= rxreq_cnt;
      if (start) begin
        busy_q <= 1'b1;
        tgl_q  <= 1'b0;
        div_q  <= cfg_reload;
        edge_q <= '0;
        bit_q  <= '0;
        rxw_q  <= '0;
        txw_q  <= tx_mode ? tx_data : '0;
        if (rxo_mode) todo_q <= (todo_q > bpw) ? todo_q - bpw : '0;
      end else if (tick) begin
        div_q  <= cfg_reload;
        tgl_q  <= ~tgl_q;
        edge_q <= edge_q + EDGE_W'(1);
        rxw_q  <= rx_next;
        if (adv) bit_q <= bit_q + LEN_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          if (!cfg_rx_off) begin
            if (rx_full) rx_overflow <= 1'b1;
            else begin
              rx_push <= 1'b1;
              rx_data <= rx_next;
            end
          end
          if (tx_mode && !tx_valid) tx_underflow <= 1'b1;
        end
      end else if (busy_q) begin
        div_q <= div_q - DIV_W'(1);
      end
    end
  end

endmodule

module spim_serial_core_chk #(
  parameter int REQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sck,
  input logic             mosi,
  input logic             cfg_cpol,
  input logic             cfg_idle_lvl,
  input logic             cfg_tx_off,
  input logic             cfg_rx_off,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             rx_overflow,
  input logic             rx_full,
  input logic             rxreq_wr,
  input logic [REQ_W-1:0] rx_todo
);

  a_r7_pop_starts_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);

  a_r7_both_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_tx_off && cfg_rx_off) |=> !busy);

  a_r10_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(!rx_full));

  a_r10_push_or_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && rx_overflow));

  a_r12_no_push_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(!cfg_rx_off));

  a_r9_result_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_overflow) |-> ($past(busy) && !busy));

  a_r8_todo_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rxreq_wr) |-> (rx_todo <= $past(rx_todo)));

  a_r2_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cfg_cpol);

  a_r6_idle_mosi: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mosi == cfg_idle_lvl);

endmodule

bind spim_serial_core spim_serial_core_chk #(.REQ_W(REQ_W)) u_chk (.*);

// File: tb/tb_spim_serial_core.sv
`timescale 1ns/1ps
module tb_spim_serial_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_len_m1 = 5'd7;
  logic        cfg_cpol = 1'b0, cfg_lead_sample = 1'b1, cfg_msb_first = 1'b1;
  logic        cfg_idle_lvl = 1'b1, cfg_tx_off = 1'b0, cfg_rx_off = 1'b0;
  logic [15:0] cfg_reload = 16'd0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_pop;
  logic        rx_full = 1'b0;
  logic        rx_push;
  logic [31:0] rx_data;
  logic        rxreq_wr = 1'b0;
  logic [15:0] rxreq_cnt = '0;
  logic [15:0] rx_todo;
  logic        sck, mosi, busy, tx_underflow, rx_overflow;
  logic        miso = 1'b0;

  always #2.5 clk = ~clk;

  spim_serial_core dut (.*);

  int nchk = 0, nfail = 0, nunder = 0, words_done = 0;
  logic [31:0] txq[$], texp[$], misoq[$];
  logic [31:0] capt, cur_miso;
  logic prev_busy = 1'b0, prev_sck = 1'b0, prev_mosi = 1'b0, pop_pending = 1'b0;
  logic started_flag = 1'b0;
  int j = 0, edges = 0, bcnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return int'(cfg_len_m1) + 1;
  endfunction

  function automatic logic [31:0] wmask();
    return (nbits() == 32) ? 32'hFFFF_FFFF : ((32'h1 << nbits()) - 32'h1);
  endfunction

  function automatic int bpos(input int k);
    return cfg_msb_first ? nbits() - 1 - k : k;
  endfunction

  function automatic logic wbit(input logic [31:0] w, input int k);
    int p = bpos(k);
    return (p >= 0 && p < 32) ? w[p] : 1'b0;
  endfunction

  // behavioural slave, FIFO model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 1'b0; prev_sck = sck; prev_mosi = mosi; pop_pending = 1'b0;
    end else begin
      if (pop_pending && txq.size() > 0) void'(txq.pop_front());
      if (busy && !prev_busy) begin
        started_flag = 1'b1;
        j = 0; capt = '0; edges = 0; bcnt = 0;
        cur_miso = (misoq.size() > 0) ? misoq.pop_front() : 32'h0;
        if (cfg_lead_sample) miso = wbit(cur_miso, 0);
      end
      if (busy) bcnt++;
      if ((busy || prev_busy) && sck !== prev_sck) begin
        edges++;
        if (prev_sck == cfg_cpol) begin
          if (cfg_lead_sample) begin
            if (j < 32) capt[bpos(j)] = prev_mosi;
          end else miso = wbit(cur_miso, j);
        end else begin
          if (cfg_lead_sample) begin
            j++;
            if (j < nbits()) miso = wbit(cur_miso, j);
          end else begin
            if (j < 32) capt[bpos(j)] = prev_mosi;
            j++;
          end
        end
      end
      if (!busy && prev_busy) begin
        logic [31:0] e;
        words_done++;
        if (!cfg_tx_off) begin
          e = (texp.size() > 0) ? (texp.pop_front() & wmask()) : 32'h0;
          check(capt == e, "R4 mosi word", capt, e);
        end else begin
          e = cfg_idle_lvl ? wmask() : 32'h0;
          check(capt == e, "R6 idle mosi", capt, e);
        end
        check(bcnt == 2 * nbits() * (int'(cfg_reload) + 1), "R5 busy length", bcnt, 2 * nbits() * (int'(cfg_reload) + 1));
        check(edges == 2 * nbits(), "R2 sck edges", edges, 2 * nbits());
        if (cfg_rx_off)
          check(!rx_push, "R12 push with rx off", {31'b0, rx_push}, 0);
        else if (rx_full)
          check(rx_overflow && !rx_push, "R10 overflow", {30'b0, rx_overflow, rx_push}, 32'h2);
        else
          check(rx_push && rx_data == (cur_miso & wmask()), "R1 rx word", rx_data, cur_miso & wmask());
      end
      if (tx_underflow) nunder++;
      prev_busy = busy; prev_sck = sck; prev_mosi = mosi;
      tx_valid = txq.size() > 0;
      tx_data  = tx_valid ? txq[0] : 32'h0;
      #1 pop_pending = tx_pop;
    end
  end

  task automatic send(input logic [31:0] t, input logic [31:0] m);
    txq.push_back(t); texp.push_back(t); misoq.push_back(m);
  endtask

  task automatic setup(input int len, input bit cpol, input bit lead, input bit msb,
                       input int br, input bit txoff, input bit rxoff);
    cfg_len_m1 = 5'(len - 1); cfg_cpol = cpol; cfg_lead_sample = lead;
    cfg_msb_first = msb; cfg_reload = 16'(br); cfg_tx_off = txoff; cfg_rx_off = rxoff;
    words_done = 0; nunder = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (txq.size() != 0 || busy || rx_todo != 0 || pop_pending);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R9 reset busy", busy, 0);
    check(sck == 1'b0, "R2 reset sck", sck, 0);
    check(mosi == 1'b1, "R6 reset mosi", mosi, 1);
    check(rx_todo == 0, "R8 reset todo", rx_todo, 0);
    check(!tx_pop, "R7 reset pop", tx_pop, 0);

    // R3 mode 0, MSB first, back to back words
    setup(8, 0, 1, 1, 0, 0, 0);
    send(32'hA5, 32'h5A); send(32'h3C, 32'hC3);
    wait_idle();
    check(words_done == 2, "R7 words run", words_done, 2);
    check(nunder == 1, "R11 underflow at burst end", nunder, 1);

    // R3 mode 3, LSB first, slower clock
    setup(13, 1, 0, 0, 2, 0, 0);
    check(sck == 1'b1, "R2 idle high", sck, 1);
    send(32'h1ABC, 32'h0F0F); send(32'h0123, 32'h1555);
    wait_idle();
    check(words_done == 2, "R7 words run", words_done, 2);

    // R1 longest word, mode 1
    setup(32, 0, 0, 1, 1, 0, 0);
    send(32'hDEAD_BEEF, 32'h8001_7FFE);
    wait_idle();

    // R1 shortest word, mode 2, LSB first
    setup(1, 1, 1, 0, 3, 0, 0);
    send(32'h1, 32'h0); send(32'h0, 32'h1); send(32'h1, 32'h1);
    wait_idle();
    check(words_done == 3, "R1 one-bit words", words_done, 3);

    // R12 transmit only
    setup(12, 0, 1, 1, 0, 0, 1);
    send(32'hA5C, 32'hFFF);
    wait_idle();

    // R8 receive only, 5 bytes of 16-bit words -> 3 words
    cfg_idle_lvl = 1'b0;
    setup(16, 0, 1, 1, 1, 1, 0);
    misoq.push_back(32'h1234); misoq.push_back(32'hFEDC); misoq.push_back(32'h8421);
    rxreq_cnt = 16'd5; rxreq_wr = 1'b1;
    @(negedge clk); rxreq_wr = 1'b0;
    @(negedge clk);
    check(rx_todo == 16'd3, "R8 todo after start", rx_todo, 3);
    rxreq_cnt = 16'd9; rxreq_wr = 1'b1;
    @(negedge clk); rxreq_wr = 1'b0;
    check(rx_todo == 16'd3, "R8 request ignored", rx_todo, 3);
    wait_idle();
    check(words_done == 3, "R8 word count", words_done, 3);
    check(rx_todo == 0, "R8 todo drained", rx_todo, 0);
    cfg_idle_lvl = 1'b1;

    // R7 both switched off: nothing starts
    setup(8, 0, 1, 1, 0, 1, 1);
    started_flag = 1'b0;
    txq.push_back(32'h55);
    repeat (40) @(negedge clk);
    check(!started_flag, "R7 both off no word", started_flag, 0);
    check(txq.size() == 1, "R7 both off no pop", txq.size(), 1);
    txq.delete();
    repeat (2) @(negedge clk);

    // R10 receive FIFO full drops word
    setup(8, 0, 1, 1, 0, 0, 0);
    rx_full = 1'b1;
    send(32'h99, 32'h66);
    wait_idle();
    rx_full = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule